// File: doc/BRIEF.md
# USB Endpoint Handshake Mode Controller

This block chooses how one full-speed USB device endpoint replies to the host. A 4-bit mode value, written by firmware, sets the reply for each token kind. The reply to an IN token is a NAK, a STALL, a data packet (zero-length or carrying the byte count supplied), or silence. The reply to an OUT or SETUP data phase is an ACK, a NAK, a STALL, or silence, and it can come with a strobe that tells the buffer logic to keep the received data.

The surrounding serial engine gives the block decoded tokens, a data-phase-complete pulse with a CRC verdict, and a pulse when the host ACKs IN data. Two armed modes go back to their NAK counterparts on their own after a successful transaction. Firmware can therefore arm the endpoint once and then poll the mode to learn that the transfer finished.

Top module: `usbEpHandshake`

## Requirements
- R1: After reset the mode is 4'b0000, hsKind is 0 (none), txSend and rxAccept are 0, and txLen is 0.
- R2: Every reply is registered. It appears in the cycle after the edge that samples the triggering input and lasts exactly one cycle. A cycle never carries both txSend and a handshake.
- R3: Mode 0000 (disabled) and the reserved codes 0100, 1010 and 1110 produce no handshake, no data and no accept for any token.
- R4: Mode 0001 NAKs both IN and OUT. Mode 0011 STALLs both IN and OUT. hsKind encodes none=0, ACK=1, NAK=2, STALL=3.
- R5: Mode 0010 (control status OUT) STALLs IN and ACKs and accepts OUT. Mode 0110 (control status IN) sends a zero-length packet on IN and STALLs OUT.
- R6: Mode 0101 accepts OUT data with no handshake. Mode 0111 sends txCount bytes on IN with no handshake. Neither mode ever drives a handshake.
- R7: Mode 1000 NAKs OUT and ignores IN. Mode 1100 NAKs IN and ignores OUT.
- R8: In mode 1001 with stallReq low, a good OUT data phase gives ACK and accept, and the mode becomes 1000 on that same edge.
- R9: In mode 1101 with stallReq low, IN sends txCount bytes and arms the endpoint. A later hostAck changes the mode to 1100. A hostAck that arrives while not armed has no effect.
- R10: With stallReq high, mode 1001 STALLs OUT and mode 1101 STALLs IN. In both cases no data moves and the mode stays the same.
- R11: Mode 1011 ACKs and accepts OUT and sends zero-length data on IN. Mode 1111 sends txCount bytes on IN and ACKs and accepts OUT.
- R12: A SETUP data phase gets ACK and accept only in modes 0001, 0010, 0011, 0110, 1011 and 1111. In every other mode it gets no reply. Token codes are none=0, SETUP=1, IN=2, OUT=3.
- R13: A data phase with crcOk low, or one with no SETUP/OUT token pending, gives no handshake and no accept and leaves the mode unchanged.
- R14: A firmware write sets the mode on the next edge. It wins over an automatic fallback on the same edge, while that cycle's reply still follows the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tokKind | input | 2 | Decoded token this cycle: 0 none, 1 SETUP, 2 IN, 3 OUT |
| dataDone | input | 1 | Pulse: a SETUP/OUT data phase has finished |
| crcOk | input | 1 | CRC verdict that comes with dataDone |
| hostAck | input | 1 | Pulse: the host ACKed the IN data just sent |
| txCount | input | CNT_W | Payload length for counted IN replies |
| stallReq | input | 1 | Stall flag for the armed modes |
| modeWe | input | 1 | Firmware mode write strobe |
| modeWrData | input | 4 | Mode value to write |
| hsKind | output | 2 | Handshake to send: 0 none, 1 ACK, 2 NAK, 3 STALL |
| txSend | output | 1 | Pulse: send a data packet |
| txLen | output | CNT_W | Length of that packet (0 for zero-length) |
| rxAccept | output | 1 | Pulse: keep the received data |
| modeNow | output | 4 | Current mode value |

## Verification
The bench builds the block with its default CNT_W of 10. That width lets a single test exercise an isochronous IN length of 700 bytes, longer than any bulk packet, next to the short counted replies of 12 and 64 bytes. The same build covers both automatic fallbacks, the stall overrides, the pending-token and CRC rules, and a firmware write that collides with a fallback on the same edge.

// File: rtl/usbEpPkg.sv
package usbEpPkg;

  typedef enum logic [1:0] {
    TOK_NONE  = 2'd0,
    TOK_SETUP = 2'd1,
    TOK_IN    = 2'd2,
    TOK_OUT   = 2'd3
  } tokKindE;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hsKindE;

  localparam logic [3:0] M_OFF          = 4'b0000;
  localparam logic [3:0] M_NAK_BOTH     = 4'b0001;
  localparam logic [3:0] M_CTL_STAT_OUT = 4'b0010;
  localparam logic [3:0] M_STALL_BOTH   = 4'b0011;
  localparam logic [3:0] M_ISO_OUT      = 4'b0101;
  localparam logic [3:0] M_CTL_STAT_IN  = 4'b0110;
  localparam logic [3:0] M_ISO_IN       = 4'b0111;
  localparam logic [3:0] M_OUT_NAK      = 4'b1000;
  localparam logic [3:0] M_OUT_ARM      = 4'b1001;
  localparam logic [3:0] M_ACK_ANY      = 4'b1011;
  localparam logic [3:0] M_IN_NAK       = 4'b1100;
  localparam logic [3:0] M_IN_ARM       = 4'b1101;
  localparam logic [3:0] M_IN_DATA      = 4'b1111;

  // strobes from the decoder to the datapath registers
  typedef struct packed {
    hsKindE     hs;
    logic       tx;
    logic       txZero;
    logic       accept;
    logic       loadMode;
    logic [3:0] nextMode;
    logic       arm;
  } ctlStrobeT;

endpackage

// File: rtl/epRespCtrl.sv
module epRespCtrl
  import usbEpPkg::*;
(
  input  logic [3:0] mode,
  input  tokKindE    pendKind,
  input  logic       armed,
  input  tokKindE    tokKind,
  input  logic       dataDone,
  input  logic       crcOk,
  input  logic       hostAck,
  input  logic       stallReq,
  output ctlStrobeT  strb
);

  always_comb begin
    strb          = '0;
    strb.nextMode = mode;
    if (dataDone && pendKind != TOK_NONE) begin
      if (crcOk) begin
        if (pendKind == TOK_SETUP) begin
          case (mode)
            M_NAK_BOTH, M_CTL_STAT_OUT, M_STALL_BOTH,
            M_CTL_STAT_IN, M_ACK_ANY, M_IN_DATA: begin
              strb.hs     = HS_ACK;
              strb.accept = 1'b1;
            end
            default: ;
          endcase
        end else begin
          case (mode)
            M_NAK_BOTH, M_OUT_NAK:       strb.hs = HS_NAK;
            M_STALL_BOTH, M_CTL_STAT_IN: strb.hs = HS_STALL;
            M_CTL_STAT_OUT, M_ACK_ANY, M_IN_DATA: begin
              strb.hs     = HS_ACK;
              strb.accept = 1'b1;
            end
            M_ISO_OUT: strb.accept = 1'b1;
            M_OUT_ARM: begin
              if (stallReq) begin
                strb.hs = HS_STALL;
              end else begin
                strb.hs       = HS_ACK;
                strb.accept   = 1'b1;
                strb.loadMode = 1'b1;
                strb.nextMode = M_OUT_NAK;
              end
            end
            default: ;
          endcase
        end
      end
    end else if (tokKind == TOK_IN) begin
      case (mode)
        M_NAK_BOTH, M_IN_NAK:         strb.hs = HS_NAK;
        M_CTL_STAT_OUT, M_STALL_BOTH: strb.hs = HS_STALL;
        M_CTL_STAT_IN, M_ACK_ANY: begin
          strb.tx     = 1'b1;
          strb.txZero = 1'b1;
        end
        M_ISO_IN, M_IN_DATA: strb.tx = 1'b1;
        M_IN_ARM: begin
          if (stallReq) begin
            strb.hs = HS_STALL;
          end else begin
            strb.tx  = 1'b1;
            strb.arm = 1'b1;
          end
        end
        default: ;
      endcase
    end else if (hostAck && armed) begin
      strb.loadMode = 1'b1;
      strb.nextMode = M_IN_NAK;
    end
  end

endmodule

// File: rtl/epRespPath.sv
module epRespPath
  import usbEpPkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobeT        strb,
  input  tokKindE          tokKind,
  input  logic             dataDone,
  input  logic             crcOk,
  input  logic             hostAck,
  input  logic             stallReq,
  input  logic [CNT_W-1:0] txCount,
  input  logic             modeWe,
  input  logic [3:0]       modeWrData,
  output logic [3:0]       mode,
  output tokKindE          pendKind,
  output logic             armed,
  output hsKindE           hsKind,
  output logic             txSend,
  output logic [CNT_W-1:0] txLen,
  output logic             rxAccept
);

  logic clearArm;
  assign clearArm = modeWe || (tokKind != TOK_NONE) || hostAck;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode     <= M_OFF;
      pendKind <= TOK_NONE;
      armed    <= 1'b0;
      hsKind   <= HS_NONE;
      txSend   <= 1'b0;
      txLen    <= '0;
      rxAccept <= 1'b0;
    end else begin
      if (modeWe)             mode <= modeWrData;
      else if (strb.loadMode) mode <= strb.nextMode;

      if (tokKind == TOK_SETUP || tokKind == TOK_OUT) pendKind <= tokKind;
      else if (dataDone)                              pendKind <= TOK_NONE;

      if (strb.arm)     armed <= 1'b1;
      else if (clearArm) armed <= 1'b0;

      hsKind   <= strb.hs;
      txSend   <= strb.tx;
      txLen    <= (strb.tx && !strb.txZero) ? txCount : '0;
      rxAccept <= strb.accept;
    end
  end

  // R2: data and handshake never share a cycle
  p_excl_reply_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(txSend && (hsKind != HS_NONE || rxAccept)));

  // R3: a disabled endpoint stays silent
  p_off_silent_r3: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_OFF && !modeWe) |=> (hsKind == HS_NONE && !txSend && !rxAccept));

  // R6: isochronous modes drive no handshake
  p_iso_nohs_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == M_ISO_OUT || mode == M_ISO_IN) && !modeWe) |=> (hsKind == HS_NONE));

  // R8: armed OUT falls back after ACK
  p_out_fallback_r8: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_OUT_ARM && pendKind == TOK_OUT && dataDone && crcOk && !stallReq && !modeWe)
    |=> (mode == M_OUT_NAK && hsKind == HS_ACK && rxAccept));

  // R9: armed IN falls back after host ACK
  p_in_fallback_r9: assert property (@(posedge clk) disable iff (!rstN)
    (armed && hostAck && !modeWe && tokKind != TOK_IN && !(dataDone && pendKind != TOK_NONE))
    |=> (mode == M_IN_NAK));

  // R10: stall flag holds the armed IN mode
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_IN_ARM && tokKind == TOK_IN && stallReq && !modeWe && !(dataDone && pendKind != TOK_NONE))
    |=> (hsKind == HS_STALL && !txSend && mode == M_IN_ARM));

  // R13: bad CRC gets no reply
  p_crc_bad_r13: assert property (@(posedge clk) disable iff (!rstN)
    (dataDone && !crcOk && tokKind != TOK_IN) |=> (hsKind == HS_NONE && !rxAccept));

  // R14: firmware write lands on the next edge
  p_fw_write_r14: assert property (@(posedge clk) disable iff (!rstN)
    modeWe |=> (mode == $past(modeWrData)));

endmodule

// File: rtl/usbEpHandshake.sv
module usbEpHandshake
  import usbEpPkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       tokKind,
  input  logic             dataDone,
  input  logic             crcOk,
  input  logic             hostAck,
  input  logic [CNT_W-1:0] txCount,
  input  logic             stallReq,
  input  logic             modeWe,
  input  logic [3:0]       modeWrData,
  output logic [1:0]       hsKind,
  output logic             txSend,
  output logic [CNT_W-1:0] txLen,
  output logic             rxAccept,
  output logic [3:0]       modeNow
);

  ctlStrobeT  strb;
  tokKindE    tokE;
  tokKindE    pendKind;
  hsKindE     hsE;
  logic       armed;

  assign tokE   = tokKindE'(tokKind);
  assign hsKind = hsE;

  epRespCtrl u_ctrl (
    .mode     (modeNow),
    .pendKind (pendKind),
    .armed    (armed),
    .tokKind  (tokE),
    .dataDone (dataDone),
    .crcOk    (crcOk),
    .hostAck  (hostAck),
    .stallReq (stallReq),
    .strb     (strb)
  );

  epRespPath #(.CNT_W(CNT_W)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .tokKind    (tokE),
    .dataDone   (dataDone),
    .crcOk      (crcOk),
    .hostAck    (hostAck),
    .stallReq   (stallReq),
    .txCount    (txCount),
    .modeWe     (modeWe),
    .modeWrData (modeWrData),
    .mode       (modeNow),
    .pendKind   (pendKind),
    .armed      (armed),
    .hsKind     (hsE),
    .txSend     (txSend),
    .txLen      (txLen),
    .rxAccept   (rxAccept)
  );

endmodule

// File: tb/sim_usbEpHandshake.sv
`timescale 1ns/1ps
module sim_usbEpHandshake;

  localparam int CNT_W = 10;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [1:0]       tokKind = '0;
  logic             dataDone = 1'b0;
  logic             crcOk = 1'b0;
  logic             hostAck = 1'b0;
  logic [CNT_W-1:0] txCount = '0;
  logic             stallReq = 1'b0;
  logic             modeWe = 1'b0;
  logic [3:0]       modeWrData = '0;
  logic [1:0]       hsKind;
  logic             txSend;
  logic [CNT_W-1:0] txLen;
  logic             rxAccept;
  logic [3:0]       modeNow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // expected: {hs[1:0], tx, len[9:0], acc, mode[3:0]}
  logic [17:0] expQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;

  usbEpHandshake #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .tokKind(tokKind), .dataDone(dataDone),
    .crcOk(crcOk), .hostAck(hostAck), .txCount(txCount), .stallReq(stallReq),
    .modeWe(modeWe), .modeWrData(modeWrData), .hsKind(hsKind), .txSend(txSend),
    .txLen(txLen), .rxAccept(rxAccept), .modeNow(modeNow)
  );

  task automatic step(input int tok, input bit dd, input bit crc, input bit ack,
                      input int cnt, input bit stl, input bit we, input int wd,
                      input int eHs, input bit eTx, input int eLen, input bit eAcc,
                      input int eMode, input string tag);
    @(negedge clk);
    tokKind    = 2'(tok);
    dataDone   = dd;
    crcOk      = crc;
    hostAck    = ack;
    txCount    = CNT_W'(cnt);
    stallReq   = stl;
    modeWe     = we;
    modeWrData = 4'(wd);
    expQ.push_back({2'(eHs), eTx, 10'(eLen), eAcc, 4'(eMode)});
    tagQ.push_back(tag);
  endtask

  task automatic wr(input int m, input string tag);
    step(0, 0, 0, 0, 0, 0, 1, m, 0, 0, 0, 0, m, tag);
  endtask

  task automatic idle(input int m, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, m, tag);
  endtask

  // OUT or SETUP token followed by a good data phase
  task automatic dataPhase(input int tok, input int m, input bit stl,
                           input int eHs, input bit eAcc, input int eMode, input string tag);
    step(tok, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, m, tag);
    step(0, 1, 1, 0, 0, stl, 0, 0, eHs, 0, 0, eAcc, eMode, tag);
  endtask

  // monitor: pops one expectation per driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [17:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if ({hsKind, txSend, txLen, rxAccept, modeNow} !== e) begin
          errors++;
          $display("FAIL %s actual hs=%0d tx=%0d len=%0d acc=%0d mode=%b expected hs=%0d tx=%0d len=%0d acc=%0d mode=%b",
                   t, hsKind, txSend, txLen, rxAccept, modeNow,
                   e[17:16], e[15], e[14:5], e[4], e[3:0]);
        end
      end
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    checks++;
    if (hsKind !== 2'd0 || txSend !== 1'b0 || txLen !== '0 || rxAccept !== 1'b0 || modeNow !== 4'b0000) begin
      errors++;
      $display("FAIL R1 reset actual hs=%0d tx=%0d len=%0d acc=%0d mode=%b expected all zero",
               hsKind, txSend, txLen, rxAccept, modeNow);
    end

    // R3 disabled
    step(2, 0, 0, 0, 9, 0, 0, 0, 0, 0, 0, 0, 0, "R3 off IN");
    dataPhase(3, 0, 0, 0, 0, 0, "R3 off OUT");
    dataPhase(1, 0, 0, 0, 0, 0, "R3 off SETUP");

    // R4 / R2
    wr(4'b0001, "R14 write");
    step(2, 0, 0, 0, 0, 0, 0, 0, 2, 0, 0, 0, 4'b0001, "R4 nak IN");
    idle(4'b0001, "R2 one-cycle pulse");
    dataPhase(3, 4'b0001, 0, 2, 0, 4'b0001, "R4 nak OUT");
    wr(4'b0011, "R14 write");
    step(2, 0, 0, 0, 0, 0, 0, 0, 3, 0, 0, 0, 4'b0011, "R4 stall IN");
    dataPhase(3, 4'b0011, 0, 3, 0, 4'b0011, "R4 stall OUT");

    // R5
    wr(4'b0010, "R14 write");
    step(2, 0, 0, 0, 0, 0, 0, 0, 3, 0, 0, 0, 4'b0010, "R5 statout IN");
    dataPhase(3, 4'b0010, 0, 1, 1, 4'b0010, "R5 statout OUT");
    wr(4'b0110, "R14 write");
    step(2, 0, 0, 0, 5, 0, 0, 0, 0, 1, 0, 0, 4'b0110, "R5 statin IN zero");
    dataPhase(3, 4'b0110, 0, 3, 0, 4'b0110, "R5 statin OUT");

    // R6
    wr(4'b0101, "R14 write");
    dataPhase(3, 4'b0101, 0, 0, 1, 4'b0101, "R6 iso OUT");
    step(2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4'b0101, "R6 iso OUT ignores IN");
    wr(4'b0111, "R14 write");
    step(2, 0, 0, 0, 700, 0, 0, 0, 0, 1, 700, 0, 4'b0111, "R6 iso IN");

    // R7
    wr(4'b1000, "R14 write");
    dataPhase(3, 4'b1000, 0, 2, 0, 4'b1000, "R7 outnak OUT");
    step(2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4'b1000, "R7 outnak IN");
    wr(4'b1100, "R14 write");
    step(2, 0, 0, 0, 0, 0, 0, 0, 2, 0, 0, 0, 4'b1100, "R7 innak IN");
    dataPhase(3, 4'b1100, 0, 0, 0, 4'b1100, "R7 innak OUT");

    // R10 / R13 / R8 on armed OUT
    wr(4'b1001, "R14 write");
    dataPhase(3, 4'b1001, 1, 3, 0, 4'b1001, "R10 stall armed OUT");
    step(3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4'b1001, "R13 token");
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4'b1001, "R13 bad crc");
    step(0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4'b1001, "R13 no pending");
    dataPhase(3, 4'b1001, 0, 1, 1, 4'b1000, "R8 fallback");
    dataPhase(3, 4'b1000, 0, 2, 0, 4'b1000, "R8 now naks");

    // R9 / R10 on armed IN
    wr(4'b1101, "R14 write");
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 4'b1101, "R9 unarmed ack");
    step(2, 0, 0, 0, 64, 1, 0, 0, 3, 0, 0, 0, 4'b1101, "R10 stall armed IN");
    step(2, 0, 0, 0, 64, 0, 0, 0, 0, 1, 64, 0, 4'b1101, "R9 send");
    idle(4'b1101, "R9 waits");
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 4'b1100, "R9 fallback");
    step(2, 0, 0, 0, 0, 0, 0, 0, 2, 0, 0, 0, 4'b1100, "R9 now naks");

    // R11
    wr(4'b1011, "R14 write");
    step(2, 0, 0, 0, 33, 0, 0, 0, 0, 1, 0, 0, 4'b1011, "R11 ackany IN");
    dataPhase(3, 4'b1011, 0, 1, 1, 4'b1011, "R11 ackany OUT");
    wr(4'b1111, "R14 write");
    step(2, 0, 0, 0, 12, 0, 0, 0, 0, 1, 12, 0, 4'b1111, "R11 indata IN");
    dataPhase(3, 4'b1111, 0, 1, 1, 4'b1111, "R11 indata OUT");

    // R12
    dataPhase(1, 4'b1111, 0, 1, 1, 4'b1111, "R12 setup ok");
    wr(4'b1000, "R14 write");
    dataPhase(1, 4'b1000, 0, 0, 0, 4'b1000, "R12 setup ignored");
    wr(4'b0110, "R14 write");
    dataPhase(1, 4'b0110, 0, 1, 1, 4'b0110, "R12 setup ok");
    wr(4'b0111, "R14 write");
    dataPhase(1, 4'b0111, 0, 0, 0, 4'b0111, "R12 setup ignored");

    // R14 collision with fallback
    wr(4'b1001, "R14 write");
    step(3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4'b1001, "R14 token");
    step(0, 1, 1, 0, 0, 0, 1, 4'b0011, 1, 0, 0, 1, 4'b0011, "R14 write wins");

    // R3 reserved codes
    wr(4'b0100, "R14 write");
    step(2, 0, 0, 0, 8, 0, 0, 0, 0, 0, 0, 0, 4'b0100, "R3 rsv IN");
    dataPhase(3, 4'b0100, 0, 0, 0, 4'b0100, "R3 rsv OUT");
    wr(4'b1010, "R14 write");
    step(2, 0, 0, 0, 8, 0, 0, 0, 0, 0, 0, 0, 4'b1010, "R3 rsv IN");
    wr(4'b1110, "R14 write");
    dataPhase(1, 4'b1110, 0, 0, 0, 4'b1110, "R3 rsv SETUP");
    idle(4'b1110, "R2 idle");

    @(negedge clk);
    tokKind = '0; dataDone = 0; crcOk = 0; hostAck = 0; modeWe = 0; stallReq = 0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule